// File: doc/BRIEF.md
# Dual-Channel Edge Counter with Serial Snapshot Readout

This block counts rising edges on two independent event inputs. Channel A holds a 13-bit count and raises a one-cycle slow-carry pulse each time it rolls over, so that a wider count can be kept further downstream. Channel B holds a 24-bit count. Both channels count only while the gate input is high. A synchronous clear input sets both counts to zero.

A read-latch strobe copies both live counts into a chain of five 8-bit parallel-load shift registers. Two bytes hold channel A and three hold channel B. The processor then reads the 40 bits one at a time through a serial output. The copy is the count held at the strobe's clock edge, and counting continues while the chain is being read. The strobe is expected at least once per measurement interval.

Top module: `dual_chan_snap_counter`

## Requirements
- R1: While `rst` is high, both counts, the shift chain, `ser_out` and `a_slow` are cleared, and the first read after reset returns 40 zero bits.
- R2: Channel A adds one for each 0-to-1 transition of `a_in` sampled on `clk` while `gate` is high. A level held high for several cycles counts once.
- R3: While `gate` is low, edges on either channel leave both counts unchanged.
- R4: `clear` zeroes both counts at the next clock edge and takes priority over an edge that arrives in the same cycle.
- R5: Channel A wraps from 8191 to 0. `a_slow` is high for exactly the one cycle after the edge that causes the wrap and is low at all other times.
- R6: Channel B adds one for each rising edge of `b_in` while `gate` is high, with 24 bits of count that carry across byte boundaries.
- R7: At a clock edge where `rd_latch` is high, the chain loads the counts held before that edge, even if a counted input edge arrives in the same cycle. That edge is still counted.
- R8: After a load, `ser_out` shows the first bit, and each cycle with `ser_shift` high advances one bit. The 40 bits come out in this order, each byte MSB first: A[7:0], then three zero bits followed by A[12:8], then B[7:0], B[15:8], B[23:16]. Zeros follow once all 40 bits have been shifted out.
- R9: When `rd_latch` and `ser_shift` are both high in the same cycle, the load wins.
- R10: Input edges that arrive while the chain is being shifted are counted and appear in the next snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate | input | 1 | Count enable for both channels |
| clear | input | 1 | Synchronous clear of both counts |
| a_in | input | 1 | Channel A event input, synchronous to clk |
| b_in | input | 1 | Channel B event input, synchronous to clk |
| rd_latch | input | 1 | Snapshot strobe that loads the shift chain |
| ser_shift | input | 1 | Advance the shift chain by one bit |
| ser_out | output | 1 | Serial data, the MSB of the chain |
| a_slow | output | 1 | One-cycle pulse on each channel A rollover |

## Verification
Every count is visible only through the serial snapshot, so a wrong counter, gate or clear state shows up as wrong bits in the next 40-bit read. That read can come at most one measurement interval after the fault. A wrong byte order or a wrong bit order inside a byte gives values that are shifted or mirrored, and these are recognisable in the first bytes read out. A broken rollover detector shows within one cycle of the 8192nd edge, as a missing or misplaced `a_slow` pulse. A wrong capture edge shows as a snapshot that is off by one when an input edge and the strobe arrive together.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int SNAP_BYTE_W = 8;

  function automatic int bytes_for(input int width);
    return (width + SNAP_BYTE_W - 1) / SNAP_BYTE_W;
  endfunction
endpackage

// File: rtl/snap_edge_counter.sv
module snap_edge_counter #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         gate,
  input  logic         ev_in,
  output logic [W-1:0] count,
  output logic         carry
);
  logic ev_prev;
  logic rise;

  assign rise = ev_in & ~ev_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_prev <= 1'b0;
      count   <= '0;
      carry   <= 1'b0;
    end else begin
      ev_prev <= ev_in;
      carry   <= 1'b0;
      if (clear) begin
        count <= '0;
      end else if (gate && rise) begin
        count <= count + 1'b1;
        carry <= &count;
      end
    end
  end

  // R4: clear zeroes the count on the following cycle
  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0));

  // R3: with the gate closed, the count holds
  assert_gate_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!gate && !clear) |=> $stable(count));

  // R2: the count moves by at most one per cycle
  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (count == $past(count) || count == W'($past(count) + 1'b1)));

  // R5: the carry pulse coincides with a freshly wrapped count
  assert_carry_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    carry |-> (count == '0));

  // R5: the carry lasts one cycle
  assert_carry_single_R5: assert property (@(posedge clk) disable iff (rst)
    carry |=> !carry);
endmodule

// File: rtl/snap_piso_chain.sv
module snap_piso_chain #(
  parameter int NB = 5,
  parameter int BW = 8,
  localparam int CW = NB * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          shift,
  input  logic [CW-1:0] par,
  output logic          ser
);
  logic [BW-1:0] q [NB];
  logic [CW-1:0] flat;

  for (genvar j = 0; j < NB; j++) begin : g_byte
    logic link_in;
    if (j == NB - 1) begin : g_tail
      assign link_in = 1'b0;
    end else begin : g_link
      assign link_in = q[j+1][BW-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        q[j] <= '0;
      end else if (load) begin
        q[j] <= par[CW-1-j*BW -: BW];
      end else if (shift) begin
        q[j] <= {q[j][BW-2:0], link_in};
      end
    end

    assign flat[CW-1-j*BW -: BW] = q[j];
  end

  assign ser = q[0][BW-1];

  // R7 and R9: a load captures the parallel word, whatever shift does
  assert_load_capture_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> (flat == $past(par)));

  // R8: a shift advances the whole chain by one bit and fills with zero
  assert_shift_step_R8: assert property (@(posedge clk) disable iff (rst)
    (shift && !load) |=> (flat == {$past(flat[CW-2:0]), 1'b0}));

  // R8: with neither control, the chain holds
  assert_chain_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!shift && !load) |=> $stable(flat));
endmodule

// File: rtl/dual_chan_snap_counter.sv
module dual_chan_snap_counter #(
  parameter int A_W = 13,
  parameter int B_W = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  input  logic clear,
  input  logic a_in,
  input  logic b_in,
  input  logic rd_latch,
  input  logic ser_shift,
  output logic ser_out,
  output logic a_slow
);
  localparam int BW      = snap_pkg::SNAP_BYTE_W;
  localparam int A_BYTES = snap_pkg::bytes_for(A_W);
  localparam int B_BYTES = snap_pkg::bytes_for(B_W);
  localparam int NB      = A_BYTES + B_BYTES;
  localparam int CW      = NB * BW;
  localparam int A_PW    = A_BYTES * BW;
  localparam int B_PW    = B_BYTES * BW;

  logic [A_W-1:0]  a_count;
  logic [B_W-1:0]  b_count;
  logic            a_carry;
  logic            b_carry;
  logic [A_PW-1:0] a_pad;
  logic [B_PW-1:0] b_pad;
  logic [CW-1:0]   par_word;

  snap_edge_counter #(.W(A_W)) i_cnt_a (
    .clk(clk), .rst(rst), .clear(clear), .gate(gate),
    .ev_in(a_in), .count(a_count), .carry(a_carry)
  );

  snap_edge_counter #(.W(B_W)) i_cnt_b (
    .clk(clk), .rst(rst), .clear(clear), .gate(gate),
    .ev_in(b_in), .count(b_count), .carry(b_carry)
  );

  assign a_pad = A_PW'(a_count);
  assign b_pad = B_PW'(b_count);

  // first byte out is channel A low byte, then upward through A, then B
  for (genvar j = 0; j < NB; j++) begin : g_order
    if (j < A_BYTES) begin : g_a
      assign par_word[CW-1-j*BW -: BW] = a_pad[j*BW +: BW];
    end else begin : g_b
      assign par_word[CW-1-j*BW -: BW] = b_pad[(j-A_BYTES)*BW +: BW];
    end
  end

  snap_piso_chain #(.NB(NB), .BW(BW)) i_chain (
    .clk(clk), .rst(rst), .load(rd_latch), .shift(ser_shift),
    .par(par_word), .ser(ser_out)
  );

  assign a_slow = a_carry;

  // R6: a channel B rollover leaves a zero count behind
  assert_b_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    b_carry |-> (b_count == '0));

  // R1: the serial output is low in the cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!ser_out && !a_slow));
endmodule

// File: tb/test_dual_chan_snap_counter.sv
`timescale 1ns/100ps
module test_dual_chan_snap_counter;
  logic clk = 1'b0;
  logic rst, gate, clear, a_in, b_in, rd_latch, ser_shift;
  logic ser_out, a_slow;
  int total = 0;
  int bad = 0;
  logic [12:0] ma = '0;
  logic [23:0] mb = '0;

  always #2.5 clk = ~clk;

  dual_chan_snap_counter i_dual_chan_snap_counter (
    .clk(clk), .rst(rst), .gate(gate), .clear(clear), .a_in(a_in),
    .b_in(b_in), .rd_latch(rd_latch), .ser_shift(ser_shift),
    .ser_out(ser_out), .a_slow(a_slow)
  );

  function automatic logic [39:0] expect_word(input logic [12:0] a, input logic [23:0] b);
    return {a[7:0], 3'b000, a[12:8], b[7:0], b[15:8], b[23:16]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_edges(input int n, input bit on_a, input bit on_b);
    for (int i = 0; i < n; i++) begin
      bit wrap;
      @(negedge clk);
      check(a_slow == 1'b0, "R5 idle", 64'(a_slow), 64'd0);
      a_in = on_a; b_in = on_b;
      wrap = gate && on_a && (ma == 13'h1fff);
      if (gate) begin
        if (on_a) ma++;
        if (on_b) mb++;
      end
      @(negedge clk);
      check(a_slow == wrap, "R5 pulse", 64'(a_slow), 64'(wrap));
      a_in = 1'b0; b_in = 1'b0;
    end
  endtask

  task automatic do_read(input bit busy, input bit edge_on_latch, input bit shift_on_latch,
                         output logic [39:0] v);
    @(negedge clk);
    rd_latch = 1'b1; ser_shift = shift_on_latch;
    if (edge_on_latch) begin
      a_in = 1'b1;
      if (gate) ma++;
    end
    @(negedge clk);
    rd_latch = 1'b0; ser_shift = 1'b0; a_in = 1'b0;
    v[39] = ser_out;
    for (int i = 38; i >= 0; i--) begin
      ser_shift = 1'b1;
      if (busy) begin
        a_in = ~a_in;
        if (a_in && gate) ma++;
      end
      @(negedge clk);
      v[i] = ser_out;
    end
    ser_shift = 1'b0; a_in = 1'b0;
  endtask

  task automatic read_and_check(input string req);
    logic [39:0] v, e;
    e = expect_word(ma, mb);
    do_read(1'b0, 1'b0, 1'b0, v);
    check(v == e, req, 64'(v), 64'(e));
  endtask

  task automatic t_reset();
    rst = 1'b1; gate = 1'b0; clear = 1'b0; a_in = 1'b0; b_in = 1'b0;
    rd_latch = 1'b0; ser_shift = 1'b0;
    repeat (3) @(negedge clk);
    check(ser_out == 1'b0 && a_slow == 1'b0, "R1 outputs", 64'({ser_out, a_slow}), 64'd0);
    rst = 1'b0;
    read_and_check("R1 first read");
  endtask

  task automatic t_count_a();
    gate = 1'b1;
    drive_edges(37, 1'b1, 1'b0);
    @(negedge clk); a_in = 1'b1; ma++;
    repeat (5) @(negedge clk);
    a_in = 1'b0;
    read_and_check("R2 channel A count and held level");
  endtask

  task automatic t_count_b();
    drive_edges(300, 1'b0, 1'b1);
    read_and_check("R6 channel B across byte");
  endtask

  task automatic t_gate();
    gate = 1'b0;
    drive_edges(10, 1'b1, 1'b1);
    read_and_check("R3 gate closed");
    gate = 1'b1;
  endtask

  task automatic t_clear();
    drive_edges(4, 1'b1, 1'b1);
    @(negedge clk); clear = 1'b1; a_in = 1'b1; b_in = 1'b1;
    @(negedge clk); clear = 1'b0; a_in = 1'b0; b_in = 1'b0;
    ma = '0; mb = '0;
    read_and_check("R4 clear beats edge");
  endtask

  task automatic t_wrap();
    drive_edges(8195, 1'b1, 1'b1);
    read_and_check("R5 wrap value");
  endtask

  task automatic t_latch_edge();
    logic [39:0] v, e;
    e = expect_word(ma, mb);
    do_read(1'b0, 1'b1, 1'b0, v);
    check(v == e, "R7 pre-edge capture", 64'(v), 64'(e));
    read_and_check("R7 edge still counted");
  endtask

  task automatic t_busy();
    logic [39:0] v, e;
    e = expect_word(ma, mb);
    do_read(1'b1, 1'b0, 1'b0, v);
    check(v == e, "R10 snapshot stable", 64'(v), 64'(e));
    read_and_check("R10 edges during shift");
  endtask

  task automatic t_override();
    logic [39:0] v, e;
    @(negedge clk); rd_latch = 1'b1;
    @(negedge clk); rd_latch = 1'b0; ser_shift = 1'b1;
    repeat (10) @(negedge clk);
    ser_shift = 1'b0;
    drive_edges(3, 1'b1, 1'b1);
    e = expect_word(ma, mb);
    do_read(1'b0, 1'b0, 1'b1, v);
    check(v == e, "R9 load wins over shift", 64'(v), 64'(e));
  endtask

  task automatic t_tail();
    read_and_check("R8 order");
    ser_shift = 1'b1;
    @(negedge clk);
    check(ser_out == 1'b0, "R8 zero fill", 64'(ser_out), 64'd0);
    ser_shift = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_count_a();
    t_count_b();
    t_gate();
    t_clear();
    t_wrap();
    t_latch_edge();
    t_busy();
    t_override();
    t_tail();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule